// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block takes a serial NRZ bit stream and turns it into a line-coded waveform. It runs on a clock at twice the bit rate, so every data bit occupies two consecutive clock cycles, called the first and second half-bit. A two-bit mode input selects one of three codes: Manchester, return-to-zero, or NRZI. An internal half-bit phase flag records which half is current. Data and mode are taken only in the first half and held for the second half, so the source may change or glitch during the second half without any effect.

A build-time parameter chooses the output stage. The registered variant adds one flip-flop after the symbol logic. This costs one fast-clock cycle of latency but gives a glitch-free output. The combinational variant shows the symbol in the same cycle as the input. An NRZI level register holds the running line level and is updated only by bits sent in NRZI mode. Phase, held inputs and level all return to their start values on a synchronous active-high reset.

Top module: `line_encoder`

## Requirements
- R1: Each data bit spans two fast-clock cycles. The first cycle after reset is a first half, and the halves then alternate. The data and mode inputs are sampled only in the first half; changes to them during the second half do not affect the output.
- R2: With mode 2'b00 (Manchester), a 0 bit is sent as low then high, and a 1 bit is sent as high then low.
- R3: With mode 2'b01 (return-to-zero), a 0 bit is sent low for both halves, and a 1 bit is sent high in the first half and low in the second.
- R4: With mode 2'b10 (NRZI), a 0 bit keeps the previous line level and a 1 bit inverts it. The new level is held for both halves of the bit. The level is changed only by bits sent in NRZI mode.
- R5: With mode 2'b11 (reserved), the symbol is low in both halves.
- R6: With REGISTERED_OUT=1, line_out equals the symbol of the previous cycle and is low in the cycle after a reset. With REGISTERED_OUT=0, line_out equals the symbol of the current cycle.
- R7: A synchronous reset returns the phase to a first half and sets the NRZI level to 0, including when it is applied in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| nrz_in | input | 1 | NRZ data bit, sampled in the first half-bit |
| mode | input | 2 | Code select: 00 Manchester, 01 RZ, 10 NRZI, 11 reserved |
| line_out | output | 1 | Encoded line symbol |

## Verification
The bench builds two copies side by side from the same stimulus: one with REGISTERED_OUT=1 (the default) and one with REGISTERED_OUT=0. This puts the one-cycle latency and the zero-latency path under the same reference model. During every second half-bit, random values are driven on the data and mode inputs, so the hold behaviour is tested against noise. Random per-bit mode switching tests that the NRZI level is held while other codes are in use. A reset in the middle of a stream tests that the level and the phase restart.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
  typedef enum logic [1:0] {
    ENC_MANCH = 2'b00,
    ENC_RZ    = 2'b01,
    ENC_NRZI  = 2'b10,
    ENC_RSVD  = 2'b11
  } lenc_mode_e;
endpackage

// File: rtl/lenc_phase.sv
module lenc_phase
  import lenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       nrz_in,
  input  logic [1:0] mode,
  output logic       second_half,
  output logic       cur_bit,
  output lenc_mode_e cur_mode
);
  logic       held_bit;
  lenc_mode_e held_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_half <= 1'b0;
      held_bit    <= 1'b0;
      held_mode   <= ENC_MANCH;
    end else begin
      second_half <= ~second_half;
      if (!second_half) begin
        held_bit  <= nrz_in;
        held_mode <= lenc_mode_e'(mode);
      end
    end
  end

  assign cur_bit  = second_half ? held_bit : nrz_in;
  assign cur_mode = second_half ? held_mode : lenc_mode_e'(mode);
endmodule

// File: rtl/lenc_symbol.sv
module lenc_symbol
  import lenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       second_half,
  input  logic       cur_bit,
  input  lenc_mode_e cur_mode,
  output logic       sym
);
  logic level;
  logic level_next;

  assign level_next = level ^ cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else if (!second_half && cur_mode == ENC_NRZI) begin
      level <= level_next;
    end
  end

  always_comb begin
    unique case (cur_mode)
      ENC_MANCH: sym = second_half ? ~cur_bit : cur_bit;
      ENC_RZ:    sym = second_half ? 1'b0 : cur_bit;
      ENC_NRZI:  sym = second_half ? level : level_next;
      default:   sym = 1'b0;
    endcase
  end
endmodule

// File: rtl/lenc_outstage.sv
module lenc_outstage #(
  parameter bit REGISTERED_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sym,
  output logic line_out
);
  generate
    if (REGISTERED_OUT) begin : g_reg
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= sym;
      end
      assign line_out = q;
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign line_out = sym;
    end
  endgenerate
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import lenc_pkg::*;
#(
  parameter bit REGISTERED_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       nrz_in,
  input  logic [1:0] mode,
  output logic       line_out
);
  logic       second_half;
  logic       cur_bit;
  lenc_mode_e cur_mode;
  logic       sym;

  lenc_phase u_phase (
    .clk(clk), .rst(rst), .nrz_in(nrz_in), .mode(mode),
    .second_half(second_half), .cur_bit(cur_bit), .cur_mode(cur_mode)
  );

  lenc_symbol u_symbol (
    .clk(clk), .rst(rst), .second_half(second_half),
    .cur_bit(cur_bit), .cur_mode(cur_mode), .sym(sym)
  );

  lenc_outstage #(.REGISTERED_OUT(REGISTERED_OUT)) u_out (
    .clk(clk), .rst(rst), .sym(sym), .line_out(line_out)
  );
endmodule

// File: rtl/line_encoder_chk.sv
module line_encoder_chk
  import lenc_pkg::*;
#(
  parameter bit REGISTERED_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       second_half,
  input lenc_mode_e cur_mode,
  input logic       sym,
  input logic       line_out
);
  p_phase_alt_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> second_half != $past(second_half));

  p_manch_flip_r2: assert property (@(posedge clk) disable iff (rst)
    (second_half && cur_mode == ENC_MANCH) |-> sym != $past(sym));

  p_rz_low_r3: assert property (@(posedge clk) disable iff (rst)
    (second_half && cur_mode == ENC_RZ) |-> !sym);

  p_nrzi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (second_half && cur_mode == ENC_NRZI) |-> sym == $past(sym));

  p_rsvd_low_r5: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == ENC_RSVD) |-> !sym);

  generate
    if (REGISTERED_OUT) begin : g_lat
      p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> line_out == $past(sym));
    end else begin : g_nolat
      always_comb begin
        p_same_cycle_r6: assert (rst || line_out === sym || $isunknown(sym));
      end
    end
  endgenerate
endmodule

bind line_encoder line_encoder_chk #(.REGISTERED_OUT(REGISTERED_OUT)) u_chk (
  .clk(clk), .rst(rst), .second_half(second_half), .cur_mode(cur_mode),
  .sym(sym), .line_out(line_out)
);

// File: tb/line_encoder_bench.sv
module line_encoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nrz_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       out_reg;
  logic       out_comb;

  int tests = 0;
  int fails = 0;

  // model state
  logic       m_phase = 1'b0;
  logic       m_level = 1'b0;
  logic       m_hbit  = 1'b0;
  logic [1:0] m_hmode = 2'b00;
  logic       m_prev  = 1'b0;

  always #5 clk = ~clk;

  line_encoder #(.REGISTERED_OUT(1'b1)) u_line_encoder (
    .clk(clk), .rst(rst), .nrz_in(nrz_in), .mode(mode), .line_out(out_reg));

  line_encoder #(.REGISTERED_OUT(1'b0)) u_line_encoder_comb (
    .clk(clk), .rst(rst), .nrz_in(nrz_in), .mode(mode), .line_out(out_comb));

  function automatic logic exp_sym(input logic ph, input logic b,
                                   input logic [1:0] m, input logic lvl);
    case (m)
      2'b00:   return ph ? ~b : b;
      2'b01:   return ph ? 1'b0 : b;
      2'b10:   return ph ? lvl : (lvl ^ b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One fast-clock cycle: drive, sample mid-cycle, advance model.
  task automatic cycle(input logic r, input logic n, input logic [1:0] md,
                       input bit do_check);
    logic       b;
    logic [1:0] m;
    logic       e;
    @(negedge clk);
    rst = r; nrz_in = n; mode = md;
    #1;
    if (!m_phase) begin b = n; m = md; end
    else          begin b = m_hbit; m = m_hmode; end
    e = exp_sym(m_phase, b, m, m_level);
    if (do_check) begin
      check("R6", out_reg, m_prev);
      if (!r) begin
        if (m_phase) check({"R1 ", mode_tag(m)}, out_comb, e);
        else         check(mode_tag(m), out_comb, e);
      end
    end
    if (r) begin
      m_phase = 1'b0; m_level = 1'b0; m_prev = 1'b0;
    end else begin
      if (!m_phase) begin
        m_hbit = n; m_hmode = md;
        if (md == 2'b10) m_level = m_level ^ n;
      end
      m_prev  = e;
      m_phase = ~m_phase;
    end
  endtask

  task automatic send_bit(input logic b, input logic [1:0] md);
    logic [31:0] rnd;
    cycle(1'b0, b, md, 1'b1);
    rnd = $urandom;
    cycle(1'b0, rnd[0], rnd[2:1], 1'b1);   // second half: noise, must be ignored (R1)
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    void'($urandom(32'd4242));
    cycle(1'b1, 1'b0, 2'b00, 1'b0);
    cycle(1'b1, 1'b0, 2'b00, 1'b0);
    // reset state (R7, R6): registered output low after reset
    @(negedge clk); #1;
    check("R7", out_reg, 1'b0);
    m_prev = 1'b0;
    // Manchester directed (R2)
    send_bit(1'b0, 2'b00); send_bit(1'b1, 2'b00); send_bit(1'b1, 2'b00);
    // RZ directed (R3)
    send_bit(1'b1, 2'b01); send_bit(1'b0, 2'b01); send_bit(1'b1, 2'b01);
    // NRZI directed (R4), with other modes in between
    send_bit(1'b1, 2'b10); send_bit(1'b0, 2'b10); send_bit(1'b1, 2'b00);
    send_bit(1'b0, 2'b10); send_bit(1'b1, 2'b10); send_bit(1'b1, 2'b10);
    // reserved (R5)
    send_bit(1'b1, 2'b11); send_bit(1'b0, 2'b11);
    // set NRZI level high, then reset mid-stream (R7)
    send_bit(1'b1, 2'b10);
    cycle(1'b0, 1'b1, 2'b10, 1'b1);
    cycle(1'b1, 1'b0, 2'b00, 1'b1);
    send_bit(1'b0, 2'b10);
    send_bit(1'b1, 2'b10);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      rnd = $urandom;
      send_bit(rnd[0], (rnd[7:4] == 4'd0) ? 2'b11 : {1'b0, rnd[1]} + {1'b0, rnd[2]});
      if (rnd[15:8] == 8'd0) cycle(1'b1, rnd[16], rnd[18:17], 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule